// File: doc/BRIEF.md
# Accumulator Machine Sequencer

This block is the control and datapath core of a small one-address accumulator processor. Each instruction word holds an opcode and one operand address. The accumulator is always one input of the arithmetic unit and always takes the result. A program counter and an instruction register share one memory port, which has a single address bus, a write-data bus, a read-data bus and a request/ready handshake. Every instruction passes through a fetch cycle, a decode cycle and an execute cycle. Registers between these steps carry the fetched word and the split opcode and address fields.

At every instruction boundary the sequencer samples a level interrupt line. If that line is high and interrupts are enabled, it spends one cycle saving the program counter, masking further interrupts and jumping to a fixed vector. A return instruction restores the saved counter and unmasks interrupts. A trap input gives single-step operation. While the trap input is high, the sequencer parks in a halted state after each instruction and waits for a step pulse before it fetches the next one.

Top module: `acc_seq_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, the accumulator to 0 and the interrupt enable to 1. The first cycle after reset is a fetch, so mem_req is 1, mem_addr is 0, mem_we is 0, halted is 0 and int_ack is 0.
- R2: An instruction word carries the opcode in bits [15:12] and the operand address in bits [11:0]. The opcodes are 1 load, 2 store, 3 add, 4 subtract, 5 AND, 6 OR, 7 jump and 8 return-from-interrupt.
- R3: A fetch requests a read at the program counter. In the cycle where mem_ready is 1, it latches mem_rdata as the instruction and advances the program counter by one, modulo 4096. It is followed by exactly one decode cycle and then the execute phase.
- R4: Opcodes 1, 3, 4, 5 and 6 read the operand address during execute. When ready arrives, the accumulator takes the read data, or accumulator + data, accumulator − data, accumulator AND data, or accumulator OR data, modulo 2^16.
- R5: A store raises mem_req with mem_we=1, drives the operand address and presents the accumulator on mem_wdata. The accumulator keeps its value.
- R6: A jump loads the program counter from the address field in a single execute cycle, without raising mem_req.
- R7: In any cycle where mem_req is 1 and mem_ready is 0, the request, address and write enable are held and no register changes. Read data offered in such a cycle is never captured.
- R8: When an execute phase completes while irq is 1 and the interrupt enable is 1, one interrupt cycle follows with int_ack=1. It saves the program counter, clears the enable and loads the program counter with the vector address, 0x100 by default.
- R9: A return (opcode 8) loads the program counter from the saved value and sets the enable in one execute cycle. The interrupt test at the end of a return uses the enable as it was before the return, so a still-pending irq is taken only after one more instruction.
- R10: If trap_en is 1 at a boundary that does not enter an interrupt cycle, or at the end of an interrupt cycle, the sequencer enters the halted state. In that state halted=1, mem_req=0, and nothing changes until step is 1, after which a fetch follows. In any other state step has no effect.
- R11: Opcodes 0 and 9 to 15 are no-operations. Each takes one execute cycle, makes no memory access and changes nothing except the program-counter increment from its fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level interrupt request |
| trap_en | input | 1 | Single-step mode when 1 |
| step | input | 1 | Leave the halted state |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current request |
| acc_out | output | 16 | Accumulator |
| pc_out | output | 12 | Program counter |
| ie_out | output | 1 | Interrupt enable flag |
| int_ack | output | 1 | High during the interrupt cycle |
| halted | output | 1 | Parked waiting for step |

## Verification
The hardest case to reach is a return executed while the interrupt line is still high. The first interrupt must leave the line asserted, the handler must store and return, exactly one main-program instruction must run, and only then must the second interrupt cycle occur. The bench holds irq until it has counted two interrupt cycles and lets its cycle model predict the exact cycle of each one. A second hard case is an interrupt arriving while the sequencer is parked in single-step mode. The bench raises irq during a halt and then steps, so the interrupt cycle falls between one instruction and the next halt. Random ready latencies, with garbage on the read bus while waiting, exercise the wait behaviour throughout.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    S_FETCH  = 3'd0,
    S_DECODE = 3'd1,
    S_EXEC   = 3'd2,
    S_IRQ    = 3'd3,
    S_HALT   = 3'd4
  } seq_state_e;

  localparam logic [OP_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'h3;
  localparam logic [OP_W-1:0] OPC_SUB   = 4'h4;
  localparam logic [OP_W-1:0] OPC_AND   = 4'h5;
  localparam logic [OP_W-1:0] OPC_OR    = 4'h6;
  localparam logic [OP_W-1:0] OPC_JMP   = 4'h7;
  localparam logic [OP_W-1:0] OPC_RETI  = 4'h8;

  // opcodes that need the memory port during execute
  function automatic logic op_uses_mem(input logic [OP_W-1:0] op);
    return (op >= OPC_LOAD) && (op <= OPC_OR);
  endfunction

  // opcodes whose result lands in the accumulator
  function automatic logic op_writes_acc(input logic [OP_W-1:0] op);
    return op_uses_mem(op) && (op != OPC_STORE);
  endfunction

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (op)
      OPC_ADD: result = acc + operand;
      OPC_SUB: result = acc - operand;
      OPC_AND: result = acc & operand;
      OPC_OR:  result = acc | operand;
      default: result = operand;
    endcase
  end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic            mem_ready,
  input  logic            irq,
  input  logic            ie,
  input  logic            trap_en,
  input  logic            step,
  output seq_state_e      state
);

  seq_state_e state_n;
  logic       exec_done;

  assign exec_done = (state == S_EXEC) && (!op_uses_mem(op) || mem_ready);

  always_comb begin
    state_n = state;
    unique case (state)
      S_FETCH:  if (mem_ready) state_n = S_DECODE;
      S_DECODE: state_n = S_EXEC;
      S_EXEC: begin
        if (exec_done) begin
          if (irq && ie)    state_n = S_IRQ;
          else if (trap_en) state_n = S_HALT;
          else              state_n = S_FETCH;
        end
      end
      S_IRQ:  state_n = trap_en ? S_HALT : S_FETCH;
      S_HALT: if (step) state_n = S_FETCH;
      default: state_n = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= state_n;
  end

  // R8
  irq_masks_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IRQ) |=> (state != S_IRQ));

endmodule

// File: rtl/acc_seq_dp.sv
module acc_seq_dp
  import acc_seq_pkg::*;
#(
  parameter int               DATA_W   = 16,
  parameter int               ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [OP_W-1:0]   op_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] acc_q,
  output logic              ie_q,
  output logic [ADDR_W-1:0] addr_mux
);

  logic [DATA_W-1:0] ir_q;
  logic [ADDR_W-1:0] fld_q;
  logic [ADDR_W-1:0] save_q;
  logic [DATA_W-1:0] alu_res;
  logic              fetch_take;
  logic              exec_done;

  assign fetch_take = (state == S_FETCH) && mem_ready;
  assign exec_done  = (state == S_EXEC) && (!op_uses_mem(op_q) || mem_ready);
  assign addr_mux   = (state == S_FETCH) ? pc_q : fld_q;

  acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .acc     (acc_q),
    .operand (mem_rdata),
    .result  (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      ir_q   <= '0;
      op_q   <= OPC_NOP;
      fld_q  <= '0;
      acc_q  <= '0;
      save_q <= RESET_PC;
      ie_q   <= 1'b1;
    end else begin
      if (fetch_take) begin
        ir_q <= mem_rdata;
        pc_q <= pc_q + ADDR_W'(1);
      end
      if (state == S_DECODE) begin
        op_q  <= ir_q[DATA_W-1 -: OP_W];
        fld_q <= ir_q[ADDR_W-1:0];
      end
      if (exec_done) begin
        if (op_writes_acc(op_q)) acc_q <= alu_res;
        if (op_q == OPC_JMP) pc_q <= fld_q;
        if (op_q == OPC_RETI) begin
          pc_q <= save_q;
          ie_q <= 1'b1;
        end
      end
      if (state == S_IRQ) begin
        save_q <= pc_q;
        ie_q   <= 1'b0;
        pc_q   <= VEC_ADDR;
      end
    end
  end

  // R7
  fetch_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH && !mem_ready) |=> ($stable(pc_q) && $stable(acc_q)));

  // R8
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IRQ) |=> (pc_q == VEC_ADDR && !ie_q));

  // R9
  reti_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op_q == OPC_RETI) |=> (pc_q == $past(save_q) && ie_q));

  // R5
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op_q == OPC_STORE) |=> $stable(acc_q));

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int VEC_ADDR = 'h100,
  parameter int RESET_PC = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   irq,
  input  logic                   trap_en,
  input  logic                   step,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [DATA_W-OP_W-1:0] mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   mem_ready,
  output logic [DATA_W-1:0]      acc_out,
  output logic [DATA_W-OP_W-1:0] pc_out,
  output logic                   ie_out,
  output logic                   int_ack,
  output logic                   halted
);

  localparam int ADDR_W = DATA_W - OP_W;

  seq_state_e        state;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_mux;

  acc_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .op        (op_q),
    .mem_ready (mem_ready),
    .irq       (irq),
    .ie        (ie_out),
    .trap_en   (trap_en),
    .step      (step),
    .state     (state)
  );

  acc_seq_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RESET_PC (ADDR_W'(RESET_PC)),
    .VEC_ADDR (ADDR_W'(VEC_ADDR))
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .op_q      (op_q),
    .pc_q      (pc_out),
    .acc_q     (acc_out),
    .ie_q      (ie_out),
    .addr_mux  (addr_mux)
  );

  // memory-side strobes are decodes of registered state only
  assign mem_req   = (state == S_FETCH) || (state == S_EXEC && op_uses_mem(op_q));
  assign mem_we    = (state == S_EXEC) && (op_q == OPC_STORE);
  assign mem_addr  = addr_mux;
  assign mem_wdata = acc_out;
  assign int_ack   = (state == S_IRQ);
  assign halted    = (state == S_HALT);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10
  halt_park_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !step) |=> (halted && !mem_req && $stable(pc_out) && $stable(acc_out)));

endmodule

// File: tb/acc_seq_top_test.sv
module acc_seq_top_test;

  localparam int CLK_P = 10;
  localparam int VEC   = 'h100;

  // R2 opcode encodings used by the bench
  localparam logic [3:0] C_NOP = 4'h0, C_LD = 4'h1, C_ST = 4'h2, C_ADD = 4'h3,
                         C_SUB = 4'h4, C_AND = 4'h5, C_OR = 4'h6, C_JMP = 4'h7,
                         C_RET = 4'h8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        trap_en = 1'b0;
  logic        step = 1'b0;
  logic        mem_req, mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [15:0] acc_out;
  logic [11:0] pc_out;
  logic        ie_out, int_ack, halted;

  int n_checks = 0;
  int n_fail   = 0;

  acc_seq_top uut (
    .clk(clk), .rst(rst), .irq(irq), .trap_en(trap_en), .step(step),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .acc_out(acc_out), .pc_out(pc_out), .ie_out(ie_out),
    .int_ack(int_ack), .halted(halted)
  );

  always #(CLK_P/2) clk = ~clk;

  // bench memory and reference model state
  logic [15:0] mem [0:4095];
  int          m_st;      // 0 fetch 1 decode 2 exec 3 irq 4 halt
  logic [11:0] m_pc, m_fld, m_save;
  logic [15:0] m_ir, m_acc;
  logic [3:0]  m_op;
  logic        m_ie;
  int          max_lat = 0;
  int          wait_left = 0;
  logic [31:0] seed = 32'h1234_5678;
  int          drop_after = 0;
  int          acks = 0;
  int          writes = 0;
  int          stalls = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic model_mem_op(input logic [3:0] op);
    return op >= C_LD && op <= C_OR;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  // one clock: compare, drive, advance the model; entered and left at negedge
  task automatic tick();
    logic e_req, e_we, rdy, take, done;
    logic [11:0] e_addr;
    logic [15:0] rd;
    e_req  = (m_st == 0) || (m_st == 2 && model_mem_op(m_op));
    e_we   = (m_st == 2) && (m_op == C_ST);
    e_addr = (m_st == 0) ? m_pc : m_fld;
    check("R3/R7", "mem_req", int'(mem_req), int'(e_req));
    check("R5", "mem_we", int'(mem_we), int'(e_we));
    if (e_req) check("R3/R7", "mem_addr", int'(mem_addr), int'(e_addr));
    if (e_we)  check("R5", "mem_wdata", int'(mem_wdata), int'(m_acc));
    check("R4", "acc", int'(acc_out), int'(m_acc));
    check("R3", "pc", int'(pc_out), int'(m_pc));
    check("R10", "halted", int'(halted), int'(m_st == 4));
    check("R8", "int_ack", int'(int_ack), int'(m_st == 3));
    check("R8", "ie", int'(ie_out), int'(m_ie));
    // memory response
    rdy = 1'b0;
    if (e_req) begin
      if (wait_left == 0) begin
        rdy  = 1'b1;
        seed = seed * 32'd1103515245 + 32'd12345;
        wait_left = (max_lat == 0) ? 0 : int'(seed[23:16]) % (max_lat + 1);
      end else begin
        wait_left--;
        stalls++;
      end
    end
    rd = rdy ? mem[e_addr] : 16'hDEAD;
    mem_ready = rdy;
    mem_rdata = rd;
    if (m_st == 3) begin
      acks++;
      if (acks >= drop_after) irq = 1'b0;
    end
    // model next state
    case (m_st)
      0: if (rdy) begin m_ir = rd; m_pc = m_pc + 12'd1; m_st = 1; end
      1: begin m_op = m_ir[15:12]; m_fld = m_ir[11:0]; m_st = 2; end
      2: begin
        done = !model_mem_op(m_op) || rdy;
        if (done) begin
          take = irq && m_ie;
          case (m_op)
            C_LD:  m_acc = rd;
            C_ADD: m_acc = m_acc + rd;
            C_SUB: m_acc = m_acc - rd;
            C_AND: m_acc = m_acc & rd;
            C_OR:  m_acc = m_acc | rd;
            C_ST:  begin mem[m_fld] = m_acc; writes++; end
            C_JMP: m_pc = m_fld;
            C_RET: begin m_pc = m_save; m_ie = 1'b1; end
            default: ;
          endcase
          m_st = take ? 3 : (trap_en ? 4 : 0);
        end
      end
      3: begin m_save = m_pc; m_ie = 1'b0; m_pc = 12'(VEC); m_st = trap_en ? 4 : 0; end
      default: if (step) m_st = 0;
    endcase
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    mem_ready = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_st = 0; m_pc = '0; m_fld = '0; m_save = '0; m_ir = '0;
    m_acc = '0; m_op = C_NOP; m_ie = 1'b1; wait_left = 0; acks = 0; writes = 0;
  endtask

  task automatic load_alu_prog();
    clear_mem();
    mem[0] = {C_LD, 12'h040};  mem[1] = {C_ADD, 12'h041};
    mem[2] = {C_SUB, 12'h042}; mem[3] = {C_AND, 12'h043};
    mem[4] = {C_OR, 12'h044};  mem[5] = {C_ST, 12'h045};
    mem[6] = {C_NOP, 12'h045}; mem[7] = {4'hC, 12'h045};
    mem[8] = {C_JMP, 12'h020};
    mem[12'h020] = {C_LD, 12'h045}; mem[12'h021] = {C_JMP, 12'h021};
    mem[12'h040] = 16'h1234; mem[12'h041] = 16'hF000; mem[12'h042] = 16'h0235;
    mem[12'h043] = 16'h0F0F; mem[12'h044] = 16'h3000;
    mem[VEC]     = {C_ST, 12'h047};
    mem[VEC + 1] = {C_RET, 12'h000};
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    // A: ALU sequence, zero latency, step held high but ignored (R10)
    load_alu_prog();
    step = 1'b1;
    do_reset();
    check("R1", "reset mem_req", int'(mem_req), 1);
    check("R1", "reset addr", int'(mem_addr), 0);
    check("R1", "reset acc", int'(acc_out), 0);
    check("R1", "reset ie", int'(ie_out), 1);
    check("R1", "reset halted", int'(halted), 0);
    run(60);
    check("R4", "final acc", int'(acc_out), 16'h3F0F);
    check("R5", "stored word", int'(mem[12'h045]), 16'h3F0F);
    check("R6", "jump loop pc", int'(pc_out == 12'h021 || pc_out == 12'h022), 1);
    step = 1'b0;

    // B: same program with ready latency and garbage read data (R7)
    load_alu_prog();
    max_lat = 3;
    do_reset();
    stalls = 0;
    run(160);
    check("R7", "stalls seen", int'(stalls > 10), 1);
    check("R4", "final acc slow", int'(acc_out), 16'h3F0F);

    // C: interrupt held through return (R8, R9)
    clear_mem();
    mem[0] = {C_LD, 12'h040}; mem[1] = {C_ADD, 12'h048}; mem[2] = {C_JMP, 12'h001};
    mem[12'h040] = 16'h0010; mem[12'h048] = 16'h0001;
    mem[VEC] = {C_ST, 12'h047}; mem[VEC + 1] = {C_RET, 12'h000};
    max_lat = 1;
    do_reset();
    run(12);
    drop_after = 2;
    irq = 1'b1;
    run(150);
    check("R9", "two interrupt cycles", acks, 2);
    check("R8", "handler stored", int'(mem[12'h047] != 16'h0000), 1);
    check("R9", "enable restored", int'(ie_out), 1);

    // D: single step with an interrupt arriving while parked (R10, R8)
    load_alu_prog();
    max_lat = 1;
    trap_en = 1'b1;
    do_reset();
    run(20);
    check("R10", "parked after one", int'(halted), 1);
    check("R10", "pc after one", int'(pc_out), 1);
    step = 1'b1; run(1); step = 1'b0;
    run(15);
    check("R10", "pc after step", int'(pc_out), 2);
    drop_after = 1;
    irq = 1'b1;
    run(6);
    check("R10", "no irq while parked", acks, 0);
    step = 1'b1; run(1); step = 1'b0;
    run(15);
    check("R8", "vector after step", int'(pc_out), VEC);
    check("R8", "ie cleared", int'(ie_out), 0);
    for (int k = 0; k < 2; k++) begin
      step = 1'b1; run(1); step = 1'b0;
      run(12);
    end
    check("R9", "returned pc", int'(pc_out), 3);
    trap_en = 1'b0;

    // E: no-operation opcodes only (R11)
    clear_mem();
    mem[0] = {C_NOP, 12'h010}; mem[1] = {4'h9, 12'h011}; mem[2] = {4'hF, 12'h012};
    mem[3] = {4'hB, 12'h013};  mem[4] = {C_JMP, 12'h000};
    max_lat = 2;
    do_reset();
    run(80);
    check("R11", "acc untouched", int'(acc_out), 0);
    check("R11", "no writes", writes, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule